// File: doc/BRIEF.md
# Ping-Pong Buffer DMA Request Controller

This block sits between an endpoint's two-buffer store and an external DMA engine. It runs the request/acknowledge handshake with that engine. In the host-bound direction (IN) the DMA engine writes bytes into a free buffer. The block validates the buffer for transmission when the buffer fills or when the transfer ends. In the device-bound direction (OUT) the DMA engine reads bytes out of a full buffer. Once the whole packet has been read, the block frees that buffer.

A transfer starts when the enable goes high while the block is idle. At that point the direction and the total byte count are captured. The request is withdrawn at every programmable burst boundary and at every buffer boundary. The request is raised again only after the acknowledge has been seen low. A routing bit moves the whole request/acknowledge pair onto a second channel's pins. Bytes move on a valid/ready strobe pair. The DMA side holds `byte_valid` while it has a byte. The block back-pressures through `byte_ready`, which is high only while the request is up, the selected acknowledge is high and the enable is set. A byte counts in any cycle where both are high.

Top module: `pp_dma_req_ctrl`

## Requirements
- R1: After reset, `dreq_a`, `dreq_b`, `byte_ready`, `buf_validate`, `buf_clear` and `done` are all low, and the target buffer index is 0.
- R2: `dir_out` = 0 selects IN. In IN, the request is raised only while `dma_en` is high and the target buffer's bit in `buf_free` (bit 0 = buffer 0, bit 1 = buffer 1) is 1. The direction is captured at start.
- R3: `dir_out` = 1 selects OUT. In OUT, the request is raised only while `dma_en` is high and the target buffer's bit in `buf_full` is 1.
- R4: Once `burst_len` bytes have been accepted in one request cycle, the request is low in the next cycle. A `burst_len` of 0 acts as 1.
- R5: After a burst or buffer boundary, the request stays low until the selected acknowledge has been sampled low. It rises in the cycle after that sample.
- R6: In IN, accepting the byte that fills a buffer of `BUF_BYTES` bytes gives a one-cycle `buf_validate` pulse in the next cycle, with `buf_idx` naming that buffer.
- R7: In OUT, accepting byte number `rd_len` of the target buffer (capped at `BUF_BYTES`) gives a one-cycle `buf_clear` pulse in the next cycle, with `buf_idx` naming that buffer.
- R8: Accepting the last byte of `xfer_count` gives a one-cycle `done` pulse in the next cycle. In IN, a partly filled buffer is validated at the same time. A start with `xfer_count` = 0 pulses `done` in the next cycle and never requests.
- R9: Clearing `dma_en` drops `byte_ready` in the same cycle and the request in the next cycle, and later strobes are not accepted. In IN, a partly filled buffer is validated. No `done` follows.
- R10: Buffers alternate strictly. Each validate or clear moves the target to the other buffer, so successive `buf_idx` values alternate starting from 0. The non-target buffer's status does not raise a request.
- R11: With `route_alt` = 0 the request appears on `dreq_a` and is acknowledged by `dack_a`. With `route_alt` = 1 it appears on `dreq_b` and is acknowledged by `dack_b`. The unused request pin is held low.
- R12: `byte_ready` is high only when the request is up, the selected acknowledge is high and `dma_en` is high. A byte is accepted exactly when `byte_valid` and `byte_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | DMA enable; rising while idle starts a transfer |
| dir_out | input | 1 | 0 = IN (DMA writes buffers), 1 = OUT (DMA reads buffers) |
| burst_len | input | BURST_W | Bytes per request cycle (0 acts as 1) |
| xfer_count | input | CNT_W | Total bytes of the transfer, captured at start |
| rd_len | input | clog2(BUF_BYTES+1) | Packet length of the buffer being read in OUT |
| buf_free | input | 2 | Per-buffer free flags (IN) |
| buf_full | input | 2 | Per-buffer full flags (OUT) |
| route_alt | input | 1 | Move the request/acknowledge pair to the second channel |
| dack_a | input | 1 | Acknowledge, first channel |
| dack_b | input | 1 | Acknowledge, second channel |
| byte_valid | input | 1 | DMA side offers a byte |
| byte_ready | output | 1 | Block accepts the offered byte |
| dreq_a | output | 1 | Request, first channel |
| dreq_b | output | 1 | Request, second channel |
| buf_validate | output | 1 | One-cycle pulse: buffer ready to send (IN) |
| buf_clear | output | 1 | One-cycle pulse: buffer released (OUT) |
| buf_idx | output | 1 | Buffer named by the current pulse |
| done | output | 1 | One-cycle pulse: byte count exhausted |

## Verification
The bench targets the cycle where a burst boundary and a buffer boundary coincide. A design that kept counting the burst across that boundary would emit a different number of request cycles. It also holds the acknowledge high after a burst to show the request staying down. A design without the acknowledge-low gap would re-request at once. Disabling mid-burst with the strobe still offered must stop acceptance in that same cycle and validate the partial buffer without a done pulse. A design that finished the burst, or that lost the partial buffer, would show extra bytes or a missing validate. A zero count, a zero burst length and a non-target buffer going free are also covered, as are the buffer indices alternating across transfers. Routing is covered by checking that no request ever appears on the unused pin.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_FIN  = 2'd2
  } xfer_state_e;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/pp_dma_route.sv
// Steers the request onto one of two channel pin pairs and picks the
// matching acknowledge.
module pp_dma_route (
  input  logic route_alt,
  input  logic dreq_int,
  input  logic dack_a,
  input  logic dack_b,
  output logic dreq_a,
  output logic dreq_b,
  output logic dack_int
);
  assign dreq_a   = dreq_int & ~route_alt;
  assign dreq_b   = dreq_int &  route_alt;
  assign dack_int = route_alt ? dack_b : dack_a;
endmodule

// File: rtl/pp_dma_counters.sv
// Remaining-byte, burst and buffer-fill counters. The *_hit outputs tell
// what a byte accepted in this cycle would complete.
module pp_dma_counters #(
  parameter int CNT_W     = 12,
  parameter int BURST_W   = 6,
  parameter int BUF_BYTES = 8,
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               accept,
  input  logic               dir_out,
  input  logic [CNT_W-1:0]   xfer_count,
  input  logic [BURST_W-1:0] burst_len,
  input  logic [LEN_W-1:0]   rd_len,
  output logic               last_byte,
  output logic               burst_hit,
  output logic               buf_hit,
  output logic               fill_nz
);
  localparam logic [LEN_W-1:0] FILL_TOP = LEN_W'(BUF_BYTES - 1);

  logic [CNT_W-1:0]   rem_q;
  logic [BURST_W-1:0] bcnt_q;
  logic [LEN_W-1:0]   fill_q;
  logic [BURST_W:0]   bcnt_inc;
  logic [LEN_W:0]     fill_inc;
  logic               seg_hit;

  assign bcnt_inc  = {1'b0, bcnt_q} + 1'b1;
  assign fill_inc  = {1'b0, fill_q} + 1'b1;
  assign last_byte = (rem_q == CNT_W'(1));
  assign burst_hit = (bcnt_inc >= {1'b0, burst_len});
  assign buf_hit   = (fill_q == FILL_TOP) |
                     (dir_out & (fill_inc >= {1'b0, rd_len}));
  assign fill_nz   = (fill_q != '0);
  assign seg_hit   = burst_hit | buf_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      bcnt_q <= '0;
      fill_q <= '0;
    end else if (start) begin
      rem_q  <= xfer_count;
      bcnt_q <= '0;
      fill_q <= '0;
    end else if (accept) begin
      rem_q  <= rem_q - 1'b1;
      bcnt_q <= seg_hit ? '0 : bcnt_inc[BURST_W-1:0];
      fill_q <= buf_hit ? '0 : fill_inc[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/pp_dma_bufsel.sv
// Target buffer pointer and the registered validate/clear pulses.
module pp_dma_bufsel (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_validate,
  input  logic adv_clear,
  output logic cur_q,
  output logic validate_q,
  output logic clear_q,
  output logic idx_q
);
  logic advance;
  assign advance = adv_validate | adv_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= 1'b0;
      validate_q <= 1'b0;
      clear_q    <= 1'b0;
      idx_q      <= 1'b0;
    end else begin
      validate_q <= adv_validate;
      clear_q    <= adv_clear;
      if (advance) begin
        idx_q <= cur_q;
        cur_q <= ~cur_q;
      end
    end
  end
endmodule

// File: rtl/pp_dma_req_ctrl.sv
module pp_dma_req_ctrl
  import pp_dma_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BURST_W   = 6,
  parameter int BUF_BYTES = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             dma_en,
  input  logic                             dir_out,
  input  logic [BURST_W-1:0]               burst_len,
  input  logic [CNT_W-1:0]                 xfer_count,
  input  logic [$clog2(BUF_BYTES+1)-1:0]   rd_len,
  input  logic [1:0]                       buf_free,
  input  logic [1:0]                       buf_full,
  input  logic                             route_alt,
  input  logic                             dack_a,
  input  logic                             dack_b,
  input  logic                             byte_valid,
  output logic                             byte_ready,
  output logic                             dreq_a,
  output logic                             dreq_b,
  output logic                             buf_validate,
  output logic                             buf_clear,
  output logic                             buf_idx,
  output logic                             done
);
  localparam int LEN_W = $clog2(BUF_BYTES + 1);

  xfer_state_e state_q, state_n;
  xfer_dir_e   dir_q, dir_n;
  logic        gap_q, gap_n;
  logic        dreq_q, dreq_n;
  logic        done_q, done_n;
  logic        dack_int;
  logic        start, accept, abort;
  logic        last_byte, burst_hit, buf_hit, fill_nz;
  logic        adv_validate, adv_clear;
  logic        cur_q, cur_n, avail;

  pp_dma_route i_route (
    .route_alt (route_alt),
    .dreq_int  (dreq_q),
    .dack_a    (dack_a),
    .dack_b    (dack_b),
    .dreq_a    (dreq_a),
    .dreq_b    (dreq_b),
    .dack_int  (dack_int)
  );

  assign byte_ready = dreq_q & dack_int & dma_en;
  assign accept     = byte_valid & byte_ready;
  assign start      = (state_q == ST_IDLE) & dma_en;
  assign abort      = (state_q == ST_ACT) & ~dma_en;

  pp_dma_counters #(
    .CNT_W     (CNT_W),
    .BURST_W   (BURST_W),
    .BUF_BYTES (BUF_BYTES),
    .LEN_W     (LEN_W)
  ) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .accept     (accept),
    .dir_out    (dir_q == DIR_OUT),
    .xfer_count (xfer_count),
    .burst_len  (burst_len),
    .rd_len     (rd_len),
    .last_byte  (last_byte),
    .burst_hit  (burst_hit),
    .buf_hit    (buf_hit),
    .fill_nz    (fill_nz)
  );

  // Buffer hand-over decisions.
  always_comb begin
    adv_validate = 1'b0;
    adv_clear    = 1'b0;
    if (dir_q == DIR_IN) begin
      adv_validate = (accept & (buf_hit | last_byte)) | (abort & fill_nz);
    end else begin
      adv_clear = accept & buf_hit;
    end
  end

  pp_dma_bufsel i_bufsel (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_validate (adv_validate),
    .adv_clear    (adv_clear),
    .cur_q        (cur_q),
    .validate_q   (buf_validate),
    .clear_q      (buf_clear),
    .idx_q        (buf_idx)
  );

  // Transfer sequencing.
  always_comb begin
    state_n = state_q;
    dir_n   = dir_q;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (dma_en) begin
        dir_n = xfer_dir_e'(dir_out);
        if (xfer_count == '0) begin
          state_n = ST_FIN;
          done_n  = 1'b1;
        end else begin
          state_n = ST_ACT;
        end
      end
      ST_ACT: begin
        if (!dma_en) begin
          state_n = ST_IDLE;
        end else if (accept && last_byte) begin
          state_n = ST_FIN;
          done_n  = 1'b1;
        end
      end
      ST_FIN:  if (!dma_en) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // Request gap and next request level.
  always_comb begin
    if (start) begin
      gap_n = 1'b0;
    end else if (accept && (burst_hit || buf_hit || last_byte)) begin
      gap_n = 1'b1;
    end else if (!dack_int) begin
      gap_n = 1'b0;
    end else begin
      gap_n = gap_q;
    end
    cur_n  = cur_q ^ (adv_validate | adv_clear);
    avail  = (dir_n == DIR_OUT) ? buf_full[cur_n] : buf_free[cur_n];
    dreq_n = (state_n == ST_ACT) & dma_en & avail & ~gap_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_IN;
      gap_q   <= 1'b0;
      dreq_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      dir_q   <= dir_n;
      gap_q   <= gap_n;
      dreq_q  <= dreq_n;
      done_q  <= done_n;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/pp_dma_req_ctrl_chk.sv
module pp_dma_req_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_en,
  input logic byte_ready,
  input logic dreq_a,
  input logic dreq_b,
  input logic buf_validate,
  input logic buf_clear,
  input logic done
);
  // R11: only one request pin carries the request
  a_r11_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !(dreq_a && dreq_b));

  // R9: enable low means no request in the following cycle
  a_r9_disable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (!dreq_a && !dreq_b));

  // R12: acceptance only possible while enabled
  a_r12_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> dma_en);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: validate is a single-cycle pulse
  a_r6_validate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    buf_validate |=> !buf_validate);

  // R7: a clear never coincides with a validate
  a_r7_clear_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_clear && buf_validate));
endmodule

bind pp_dma_req_ctrl pp_dma_req_ctrl_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dma_en       (dma_en),
  .byte_ready   (byte_ready),
  .dreq_a       (dreq_a),
  .dreq_b       (dreq_b),
  .buf_validate (buf_validate),
  .buf_clear    (buf_clear),
  .done         (done)
);

// File: tb/test_pp_dma_req_ctrl.sv
module test_pp_dma_req_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 1'b0, dir_out = 1'b0, route_alt = 1'b0;
  logic [5:0] burst_len = '0;
  logic [11:0] xfer_count = '0;
  logic [3:0] rd_len = 4'd8;
  logic [1:0] buf_free = 2'b11, buf_full = 2'b11;
  logic byte_ready, dreq_a, dreq_b, buf_validate, buf_clear, buf_idx, done;
  logic drv_on = 1'b0, drv_dack = 1'b0, drv_valid = 1'b0;
  logic man_dack = 1'b0, man_valid = 1'b0;
  logic dack, byte_valid, dack_a, dack_b, dreq_sel, dreq_oth;
  int total = 0, bad = 0;
  int m_bytes = 0, m_bursts = 0, m_val = 0, m_clr = 0, m_done = 0;
  int m_idx_bad = 0, m_wrong = 0;
  logic m_idx = 1'b0, prev_sel = 1'b0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  assign dack       = drv_on ? drv_dack : man_dack;
  assign byte_valid = drv_on ? drv_valid : man_valid;
  assign dack_a     = route_alt ? 1'b0 : dack;
  assign dack_b     = route_alt ? dack : 1'b0;
  assign dreq_sel   = route_alt ? dreq_b : dreq_a;
  assign dreq_oth   = route_alt ? dreq_a : dreq_b;

  pp_dma_req_ctrl i_pp_dma_req_ctrl (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dir_out(dir_out),
    .burst_len(burst_len), .xfer_count(xfer_count), .rd_len(rd_len),
    .buf_free(buf_free), .buf_full(buf_full), .route_alt(route_alt),
    .dack_a(dack_a), .dack_b(dack_b), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .dreq_a(dreq_a), .dreq_b(dreq_b),
    .buf_validate(buf_validate), .buf_clear(buf_clear), .buf_idx(buf_idx),
    .done(done)
  );

  typedef struct packed {
    logic       dir;
    logic       route;
    logic [5:0] blen;
    logic [11:0] cnt;
    logic [3:0] rlen;
    logic [7:0] e_bytes;
    logic [7:0] e_bursts;
    logic [7:0] e_val;
    logic [7:0] e_clr;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 6'd4, 12'd16, 4'd8, 8'd16, 8'd4, 8'd2, 8'd0},
    '{1'b0, 1'b0, 6'd3, 12'd10, 4'd8, 8'd10, 8'd4, 8'd2, 8'd0},
    '{1'b1, 1'b0, 6'd8, 12'd16, 4'd8, 8'd16, 8'd2, 8'd0, 8'd2},
    '{1'b1, 1'b0, 6'd5, 12'd12, 4'd8, 8'd12, 8'd3, 8'd0, 8'd1},
    '{1'b0, 1'b1, 6'd2, 12'd4,  4'd8, 8'd4,  8'd2, 8'd1, 8'd0},
    '{1'b1, 1'b0, 6'd0, 12'd3,  4'd2, 8'd3,  8'd3, 8'd0, 8'd1}
  };

  // DMA engine model: acknowledge and offer bytes while requested.
  always begin
    @(posedge clk);
    #1;
    if (drv_on) begin
      drv_dack  = dreq_sel;
      drv_valid = dreq_sel;
    end
  end

  // Output monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid && byte_ready) m_bytes++;
      if (dreq_sel && !prev_sel) m_bursts++;
      if (dreq_oth) m_wrong++;
      if (buf_validate || buf_clear) begin
        if (buf_idx != m_idx) m_idx_bad++;
        m_idx = ~m_idx;
      end
      if (buf_validate) m_val++;
      if (buf_clear) m_clr++;
      if (done) m_done++;
      prev_sel = dreq_sel;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  task automatic clr_mon();
    m_bytes = 0; m_bursts = 0; m_val = 0; m_clr = 0; m_done = 0;
    m_idx_bad = 0; m_wrong = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #12;
    check({dreq_a, dreq_b, byte_ready, buf_validate, buf_clear, done} == 6'b0,
          "R1 outputs in reset", {dreq_a, dreq_b, byte_ready, buf_validate, buf_clear, done}, 0);
    rst_n = 1'b1;
    tick();
    check({dreq_a, dreq_b, byte_ready, buf_validate, buf_clear, done} == 6'b0,
          "R1 outputs after reset", {dreq_a, dreq_b, byte_ready, buf_validate, buf_clear, done}, 0);

    // Vector walk: R2 R3 R4 R6 R7 R8 R10 R11 R12
    for (int v = 0; v < 6; v++) begin
      clr_mon();
      dir_out = VECS[v].dir; route_alt = VECS[v].route;
      burst_len = VECS[v].blen; xfer_count = VECS[v].cnt; rd_len = VECS[v].rlen;
      buf_free = 2'b11; buf_full = 2'b11;
      drv_on = 1'b1; dma_en = 1'b1;
      for (int c = 0; c < 400 && m_done == 0; c++) tick();
      tick();
      dma_en = 1'b0; drv_on = 1'b0;
      tick(); tick();
      check(m_bytes == int'(VECS[v].e_bytes), "R12 bytes accepted", m_bytes, VECS[v].e_bytes);
      check(m_bursts == int'(VECS[v].e_bursts), "R4 request cycles", m_bursts, VECS[v].e_bursts);
      check(m_val == int'(VECS[v].e_val), "R6 validate pulses", m_val, VECS[v].e_val);
      check(m_clr == int'(VECS[v].e_clr), "R7 clear pulses", m_clr, VECS[v].e_clr);
      check(m_done == 1, "R8 done pulses", m_done, 1);
      check(m_idx_bad == 0, "R10 buffer index alternation", m_idx_bad, 0);
      check(m_wrong == 0, "R11 unused request pin", m_wrong, 0);
    end
    route_alt = 1'b0;

    // R2 and R10: IN request depends on the target buffer being free
    clr_mon();
    dir_out = 1'b0; burst_len = 6'd4; xfer_count = 12'd4; buf_free = 2'b00;
    dma_en = 1'b1;
    repeat (5) tick();
    check(dreq_a == 1'b0, "R2 no request with no free buffer", dreq_a, 0);
    buf_free = m_idx ? 2'b01 : 2'b10;
    repeat (3) tick();
    check(dreq_a == 1'b0, "R10 non-target free buffer ignored", dreq_a, 0);
    buf_free = m_idx ? 2'b10 : 2'b01;
    tick();
    check(dreq_a == 1'b1, "R2 request once target free", dreq_a, 1);
    dma_en = 1'b0;
    tick(); tick();

    // R3: OUT request depends on the target buffer being full
    dir_out = 1'b1; buf_free = 2'b11; buf_full = 2'b00;
    dma_en = 1'b1;
    repeat (5) tick();
    check(dreq_a == 1'b0, "R3 no request with no full buffer", dreq_a, 0);
    buf_full = m_idx ? 2'b10 : 2'b01;
    tick();
    check(dreq_a == 1'b1, "R3 request once target full", dreq_a, 1);
    dma_en = 1'b0;
    tick(); tick();
    buf_full = 2'b11;

    // R9: disable mid-burst with the strobe still offered
    clr_mon();
    dir_out = 1'b0; burst_len = 6'd8; xfer_count = 12'd20;
    drv_on = 1'b1; dma_en = 1'b1;
    for (int c = 0; c < 50 && m_bytes < 3; c++) tick();
    man_dack = 1'b1; man_valid = 1'b1; drv_on = 1'b0;
    dma_en = 1'b0;
    #1;
    check(byte_ready == 1'b0, "R9 ready low with enable low", byte_ready, 0);
    tick();
    check(dreq_a == 1'b0, "R9 request low next cycle", dreq_a, 0);
    check(buf_validate == 1'b1, "R9 partial buffer validated", buf_validate, 1);
    repeat (4) tick();
    check(m_bytes == 3, "R9 no bytes after disable", m_bytes, 3);
    check(m_done == 0, "R9 no done on disable", m_done, 0);
    check(m_idx_bad == 0, "R10 index after partial validate", m_idx_bad, 0);
    man_dack = 1'b0; man_valid = 1'b0;
    tick();

    // R4 and R5: acknowledge held high keeps the request down
    clr_mon();
    burst_len = 6'd2; xfer_count = 12'd6;
    dma_en = 1'b1;
    for (int c = 0; c < 10 && !dreq_a; c++) tick();
    man_dack = 1'b1; man_valid = 1'b1;
    tick();
    check(dreq_a == 1'b1, "R4 request held inside burst", dreq_a, 1);
    tick();
    check(dreq_a == 1'b0, "R4 request drops after burst", dreq_a, 0);
    man_valid = 1'b0;
    repeat (4) tick();
    check(dreq_a == 1'b0, "R5 no request while acknowledge high", dreq_a, 0);
    man_dack = 1'b0;
    tick();
    check(dreq_a == 1'b1, "R5 request after acknowledge low", dreq_a, 1);
    dma_en = 1'b0;
    tick(); tick();
    check(m_bytes == 2, "R12 bytes in one burst", m_bytes, 2);

    // R8: zero count finishes at once
    clr_mon();
    xfer_count = 12'd0;
    dma_en = 1'b1;
    tick();
    check(done == 1'b1, "R8 done for zero count", done, 1);
    tick();
    check(done == 1'b0, "R8 done one cycle", done, 0);
    repeat (3) tick();
    check(m_bursts == 0, "R8 no request for zero count", m_bursts, 0);
    dma_en = 1'b0;
    tick();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule